// File: doc/BRIEF.md
# UART Transmit Queue with Empty Interrupt

This block is the transmit half of a byte-wide UART register front end. Software writes characters into the holding register. They enter a 16-deep first-in first-out queue, and the external serial shifter drains that queue one byte per pop strobe. The block does not contain the shifter, the receiver, the baud generator or the modem lines.

The block reports queue state in three ways:
- A status register has a bit that reads 1 while the queue holds nothing.
- An active-high ready pin drops low while all 16 places are taken. Polling software can keep writing until that pin says the queue is full.
- An interrupt source latches when the shifter takes the last stored byte. It is released by the next write to the holding register, or by reading the identification register while that register names this source. The interrupt pin is the latched source qualified by a software enable bit.

Top module: `uart_txq`

## Requirements
- R1: Bytes written at offset 0 are presented on `sh_data` in write order. `sh_valid` is 1 exactly when at least one byte is stored. Each `sh_pop` while `sh_valid` is 1 removes the front byte. Capacity is 16 bytes.
- R2: A write at offset 0 while 16 bytes are stored is discarded. The 16 stored bytes still come out unchanged and in order.
- R3: `tx_rdy` is 1 while fewer than 16 bytes are stored and 0 while 16 are stored.
- R4: A read at offset 5 returns 8'h20 when the queue is empty and 8'h00 otherwise. Bit 5 is the empty flag.
- R5: When a pop removes the last stored byte, the empty-interrupt source becomes pending at that clock edge.
- R6: Any write at offset 0 clears a pending empty-interrupt source.
- R7: A read at offset 2 returns 8'h02 while the source is pending and enabled, and 8'h01 otherwise. A read that returns 8'h02 clears the source. A read that returns 8'h01 leaves it unchanged.
- R8: Once cleared, the source stays clear while the queue remains empty. It is raised again only by a new pop of a last byte.
- R9: Bit 1 of the register at offset 1 is the interrupt enable. It reads back at offset 1 with all other bits 0. `irq` equals pending AND enable, so enabling while the source is pending raises `irq`.
- R10: A pop while the queue is empty has no effect: the queue stays empty and no interrupt is raised.
- R11: After reset, the queue is empty, the source is clear, the enable is 0, `irq` is 0 and `tx_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (offset 2 has a side effect) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current `reg_addr` |
| sh_pop | input | 1 | Shifter takes the front byte |
| sh_data | output | 8 | Front byte of the queue |
| sh_valid | output | 1 | Queue holds at least one byte |
| tx_rdy | output | 1 | Queue has a free place |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
Every internal fault of this block shows at the ports within one clock edge. A pointer or count error surfaces as a byte out of order at `sh_data`, or as `tx_rdy` and the offset-5 flag disagreeing with the number of accepted writes. A pending-flag error shows as `irq` or the offset-2 code differing from what the pop, write and read history implies. The tests therefore drive full fills and drains, a dropped write at capacity, and each clear path. Each is observed at the first negative clock edge after the causing edge.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned REG_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_HOLD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IDENT = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;

  localparam int unsigned IEN_BIT         = 1;
  localparam int unsigned LSTAT_EMPTY_BIT = 5;

  localparam logic [REG_W-1:0] ID_NONE    = 8'h01;
  localparam logic [REG_W-1:0] ID_TXEMPTY = 8'h02;

  typedef struct packed {
    logic hold_wr;
    logic ien_wr;
    logic ident_rd;
  } bus_dec_t;
endpackage

// File: rtl/txq_rst_sync.sv
module txq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                din,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         empty,
  output logic                         full,
  output logic                         drain
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign drain   = pop_ok & ~push_ok & (cnt_q == CNT_ONE);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = ptr_inc(wptr_q);
    if (pop_ok)  rptr_d = ptr_inc(rptr_q);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= din;
  end

  assign dout = mem[rptr_q];
  assign cnt  = cnt_q;
endmodule

// File: rtl/txq_irq_ctl.sv
module txq_irq_ctl
  import uart_txq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bus_dec_t         dec,
  input  logic             ien_din,
  input  logic             drain,
  output logic             int_en,
  output logic             int_pend,
  output logic             irq,
  output logic [REG_W-1:0] ident
);
  logic en_q, en_d;
  logic pend_q, pend_d;
  logic clr;

  assign irq   = pend_q & en_q;
  assign ident = irq ? ID_TXEMPTY : ID_NONE;
  assign clr   = dec.hold_wr | (dec.ident_rd & irq);

  always_comb begin
    en_d = en_q;
    if (dec.ien_wr) en_d = ien_din;
    pend_d = pend_q;
    if (clr)   pend_d = 1'b0;
    if (drain) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign int_en   = en_q;
  assign int_pend = pend_q;
endmodule

// File: rtl/txq_reg_rd.sv
module txq_reg_rd
  import uart_txq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              int_en,
  input  logic [REG_W-1:0]  ident,
  input  logic              empty,
  output logic [REG_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    case (addr)
      OFS_IEN:   rdata[IEN_BIT] = int_en;
      OFS_IDENT: rdata = ident;
      OFS_LSTAT: rdata[LSTAT_EMPTY_BIT] = empty;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_txq.sv
module uart_txq
  import uart_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              sh_pop,
  output logic [REG_W-1:0]  sh_data,
  output logic              sh_valid,
  output logic              tx_rdy,
  output logic              irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic            rst_q_n;
  bus_dec_t        dec;
  logic [CW-1:0]   fifo_cnt;
  logic            fifo_empty, fifo_full, fifo_drain;
  logic            int_en, int_pend;
  logic [REG_W-1:0] ident;

  always_comb begin
    dec.hold_wr  = reg_wr & (reg_addr == OFS_HOLD);
    dec.ien_wr   = reg_wr & (reg_addr == OFS_IEN);
    dec.ident_rd = reg_rd & (reg_addr == OFS_IDENT);
  end

  txq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  txq_fifo #(.DW(REG_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_q_n),
    .push(dec.hold_wr), .pop(sh_pop), .din(reg_wdata),
    .dout(sh_data), .cnt(fifo_cnt),
    .empty(fifo_empty), .full(fifo_full), .drain(fifo_drain)
  );

  txq_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_q_n), .dec(dec),
    .ien_din(reg_wdata[IEN_BIT]), .drain(fifo_drain),
    .int_en(int_en), .int_pend(int_pend), .irq(irq), .ident(ident)
  );

  txq_reg_rd u_rd (
    .addr(reg_addr), .int_en(int_en), .ident(ident),
    .empty(fifo_empty), .rdata(reg_rdata)
  );

  assign sh_valid = ~fifo_empty;
  assign tx_rdy   = ~fifo_full;
endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic          sh_pop,
  input logic          sh_valid,
  input logic          tx_rdy,
  input logic          irq,
  input logic [CW-1:0] fifo_cnt,
  input logic          int_pend,
  input logic          int_en
);
  logic hold_wr;
  assign hold_wr = reg_wr & (reg_addr == 3'd0);

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!tx_rdy && hold_wr && !sh_pop) |=> (!tx_rdy && $stable(fifo_cnt)));

  // R3
  full_valid_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !tx_rdy |-> sh_valid);

  // R5
  drain_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sh_pop && fifo_cnt == CW'(1) && !hold_wr) |=> int_pend);

  // R6
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    hold_wr |=> !int_pend);

  // R4
  pend_empty_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    int_pend |-> !sh_valid);

  // R8
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!int_pend && !sh_valid && !hold_wr) |=> !int_pend);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq |-> (int_en && int_pend));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!sh_valid && sh_pop && !hold_wr && !reg_rd) |=> (!sh_valid && $stable(irq)));
endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .sh_pop(sh_pop), .sh_valid(sh_valid),
  .tx_rdy(tx_rdy), .irq(irq), .fifo_cnt(fifo_cnt),
  .int_pend(int_pend), .int_en(int_en)
);

// File: tb/sim_uart_txq.sv
`timescale 1ns/1ps
module sim_uart_txq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, sh_pop = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, sh_data;
  logic       sh_valid, tx_rdy, irq;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  uart_txq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sh_pop(sh_pop), .sh_data(sh_data), .sh_valid(sh_valid),
    .tx_rdy(tx_rdy), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); sh_pop = 1'b1;
    #1 d = sh_data;
    @(negedge clk); sh_pop = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R11 irq", irq, 0);
    chk("R11 tx_rdy", tx_rdy, 1);
    chk("R11 sh_valid", sh_valid, 0);
    rd(3'd5, d); chk("R11/R4 lstat", d, 8'h20);
    rd(3'd2, d); chk("R11/R7 ident", d, 8'h01);
    rd(3'd1, d); chk("R11/R9 ien", d, 8'h00);
  endtask

  task automatic t_fill_drain;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin
      chk("R3 ready before full", tx_rdy, 1);
      wr(3'd0, 8'hA0 + 8'(i));
    end
    chk("R3 full ready low", tx_rdy, 0);
    chk("R1 valid", sh_valid, 1);
    rd(3'd5, d); chk("R4 lstat nonempty", d, 8'h00);
    wr(3'd0, 8'h55);
    chk("R2 still full", tx_rdy, 0);
    for (int i = 0; i < 16; i++) begin
      pop(d); chk("R1/R2 order", d, 8'hA0 + 8'(i));
    end
    chk("R1 empty after drain", sh_valid, 0);
    chk("R9 irq gated off", irq, 0);
    rd(3'd2, d); chk("R7 ident disabled", d, 8'h01);
    wr(3'd1, 8'h02);
    chk("R5/R9 irq after enable", irq, 1);
    rd(3'd1, d); chk("R9 ien readback", d, 8'h02);
    rd(3'd5, d); chk("R4 lstat empty", d, 8'h20);
    rd(3'd2, d); chk("R7 ident code", d, 8'h02);
    chk("R7 cleared by read", irq, 0);
    rd(3'd2, d); chk("R7 ident after clear", d, 8'h01);
    repeat (5) @(negedge clk);
    chk("R8 no refire", irq, 0);
  endtask

  task automatic t_empty_pop;
    logic [7:0] d;
    pop(d);
    chk("R10 valid", sh_valid, 0);
    chk("R10 irq", irq, 0);
    rd(3'd5, d); chk("R10 lstat", d, 8'h20);
  endtask

  task automatic t_write_clear;
    logic [7:0] d;
    wr(3'd0, 8'h3C);
    pop(d); chk("R1 data", d, 8'h3C);
    chk("R5 irq set", irq, 1);
    wr(3'd0, 8'h77);
    chk("R6 write clears", irq, 0);
    chk("R1 valid one", sh_valid, 1);
    pop(d); chk("R1 data2", d, 8'h77);
    chk("R8 new transition fires", irq, 1);
    wr(3'd1, 8'h00);
    chk("R9 disable masks", irq, 0);
    rd(3'd2, d); chk("R7 masked ident", d, 8'h01);
    wr(3'd1, 8'h02);
    chk("R7 read 01 kept pending", irq, 1);
    rd(3'd2, d); chk("R7 ident 02", d, 8'h02);
    chk("R7 cleared", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_drain();
    t_empty_pop();
    t_write_clear();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule